// File: doc/BRIEF.md
# Prescaled Up/Down Interrupt Timer

This block is an interrupt timer for a cartridge memory controller. A prescaler and a main counter, both 8 bits wide, sit in series. Every tick steps the prescaler. When the prescaler reaches its rollover point, the main counter steps once. When the main counter wraps, the interrupt line is raised. Both counters can run upward or downward. The prescaler can also be shortened so that only its low three bits decide when it rolls over.

Ticks come from one of three sources, chosen by software. The first is a CPU clock-enable pulse, worth one tick. The second is a scanline pulse, worth eight ticks. The third is any change on the video address bus, worth two ticks. All ticks that arrive in one clock are applied in that same clock as single steps, one after another.

Software reaches the timer through a byte-wide write port with a 3-bit register offset. A value written to either counter is first XORed with a key register that software can also write. The interrupt is a level. It stays high until software acknowledges it or disables the timer.

Top module: `irq_tick_timer`

## Requirements
- R1: A synchronous reset sets every register to zero. After reset the interrupt is low, the timer is disabled, and counting is stopped.
- R2: Bits [7:6] of the mode register (offset 1) set the direction: 01 counts up, 10 counts down. With 00 or 11, neither counter changes and no interrupt can be raised. The held values are still there when counting resumes.
- R3: Counting up, each tick adds one to the prescaler. When the masked prescaler becomes zero, the main counter adds one. If the main counter becomes 0x00 while the timer is enabled, the interrupt is raised.
- R4: Counting down, each tick subtracts one from the prescaler. When the masked prescaler equals the mask, the main counter subtracts one. If the main counter becomes 0xFF while the timer is enabled, the interrupt is raised.
- R5: Mode bit 2 set gives a prescaler mask of 0x07. Mode bit 2 clear gives a mask of 0xFF.
- R6: Mode bits [1:0] choose the tick source. Value 0 is the CPU pulse (one tick). Value 1 is the scanline pulse (eight ticks). Value 2 is a video address that differs from its value in the previous clock (two ticks). Value 3 produces no ticks. Pulses from a source that is not selected have no effect.
- R7: All ticks that arrive in one clock are applied in that clock as consecutive single steps.
- R8: Writing offset 4 loads the prescaler, and writing offset 5 loads the main counter. In both cases the value stored is the written byte XORed with the key held at offset 6. A load overrides any ticks in the same clock.
- R9: The interrupt stays high until one of two writes clears it: offset 2, or offset 0 with data bit 0 clear. Offset 3, or offset 0 with data bit 0 set, enables the timer. If a clearing write and a wrap fall in the same clock, the clearing write wins.
- R10: A wrap while the timer is disabled raises no interrupt, and enabling the timer afterward does not raise one either.
- R11: Writes to offset 7 are accepted and have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| cpuTick | input | 1 | CPU cycle pulse, one tick |
| lineTick | input | 1 | Scanline pulse, eight ticks |
| vidAddr | input | 14 | Video address bus; a change gives two ticks |
| irq | output | 1 | Interrupt request, active-high level |

## Verification
The bench checks the exact tick at which the interrupt rises, using the narrow mask, the full mask and both directions. A design that compared the unmasked prescaler, or checked for rollover before stepping instead of after, would raise the interrupt several ticks early or late. It also targets the multi-tick sources. A design that took a scanline or an address change as a single step would need eight or two times as many events before it fired. The remaining tests cover the XOR on loads, ticks that arrive while counting is stopped or from a source that is not selected, wraps while the timer is disabled, and a clearing write in the same clock as a wrap. A wrong design would fire spuriously, lose its held count, or let the interrupt survive the acknowledge.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  typedef enum logic [2:0] {
    OFS_ENABLE = 3'd0,
    OFS_MODE   = 3'd1,
    OFS_OFF    = 3'd2,
    OFS_ON     = 3'd3,
    OFS_PRE    = 3'd4,
    OFS_MAIN   = 3'd5,
    OFS_KEY    = 3'd6,
    OFS_SIZE   = 3'd7
  } regOfs_e;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_LINE  = 2'd1,
    SRC_VIDEO = 2'd2,
    SRC_WRITE = 2'd3
  } tickSrc_e;

  localparam logic [1:0] DIR_UP   = 2'b01;
  localparam logic [1:0] DIR_DOWN = 2'b10;

  typedef struct packed {
    logic loadPre;
    logic loadMain;
    logic ackIrq;
    logic irqEnable;
    logic countUp;
    logic countDown;
    logic narrow;
  } ctlStrobes_t;

endpackage

// File: rtl/irqtmr_ctrl.sv
module irqtmr_ctrl
  import irqtmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int VA_W       = 14,
  parameter int LINE_STEPS = 8,
  parameter int VID_STEPS  = 2,
  parameter int STEP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              cpuTick,
  input  logic              lineTick,
  input  logic [VA_W-1:0]   vidAddr,
  output ctlStrobes_t       strb,
  output logic [STEP_W-1:0] stepCnt,
  output logic [CNT_W-1:0]  loadVal
);

  logic [1:0]       dirSel;
  tickSrc_e         srcSel;
  logic             narrowSel;
  logic             enableReg;
  logic [CNT_W-1:0] keyReg;
  logic [VA_W-1:0]  lastAddr;
  regOfs_e          ofs;
  logic [STEP_W-1:0] rawSteps;
  logic             running;

  assign ofs = regOfs_e'(wrAddr);

  // Configuration registers; the address history is kept in every mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      dirSel    <= '0;
      srcSel    <= SRC_CPU;
      narrowSel <= 1'b0;
      enableReg <= 1'b0;
      keyReg    <= '0;
      lastAddr  <= '0;
    end else begin
      lastAddr <= vidAddr;
      if (wrEn) begin
        case (ofs)
          OFS_ENABLE: enableReg <= wrData[0];
          OFS_MODE: begin
            dirSel    <= wrData[7:6];
            narrowSel <= wrData[2];
            srcSel    <= tickSrc_e'(wrData[1:0]);
          end
          OFS_OFF:  enableReg <= 1'b0;
          OFS_ON:   enableReg <= 1'b1;
          OFS_KEY:  keyReg    <= wrData;
          default:  ;
        endcase
      end
    end
  end

  // Tick weight of this clock for the selected source.
  always_comb begin
    case (srcSel)
      SRC_CPU:   rawSteps = cpuTick  ? STEP_W'(1)          : '0;
      SRC_LINE:  rawSteps = lineTick ? STEP_W'(LINE_STEPS) : '0;
      SRC_VIDEO: rawSteps = (vidAddr != lastAddr) ? STEP_W'(VID_STEPS) : '0;
      default:   rawSteps = '0;
    endcase
  end

  assign running = (dirSel == DIR_UP) || (dirSel == DIR_DOWN);
  assign stepCnt = running ? rawSteps : '0;
  assign loadVal = wrData ^ keyReg;

  always_comb begin
    strb.loadPre   = wrEn && (ofs == OFS_PRE);
    strb.loadMain  = wrEn && (ofs == OFS_MAIN);
    strb.ackIrq    = wrEn && ((ofs == OFS_OFF) || ((ofs == OFS_ENABLE) && !wrData[0]));
    strb.irqEnable = enableReg;
    strb.countUp   = (dirSel == DIR_UP);
    strb.countDown = (dirSel == DIR_DOWN);
    strb.narrow    = narrowSel;
  end

endmodule

// File: rtl/irqtmr_core.sv
module irqtmr_core
  import irqtmr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int NARROW_W  = 3,
  parameter int MAX_STEPS = 8,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strb,
  input  logic [STEP_W-1:0] stepCnt,
  input  logic [CNT_W-1:0]  loadVal,
  output logic              irq
);

  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((1 << NARROW_W) - 1);
  localparam logic [CNT_W-1:0] FULL_MASK   = '1;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] mainCnt;
  logic [CNT_W-1:0] preMask;
  logic [CNT_W-1:0] preNext;
  logic [CNT_W-1:0] mainNext;
  logic             wrapHit;

  assign preMask = strb.narrow ? NARROW_MASK : FULL_MASK;

  // Unrolled chain of single steps; stage k is live when k < stepCnt.
  always_comb begin
    logic [CNT_W-1:0] p;
    logic [CNT_W-1:0] m;
    logic             h;
    p = preCnt;
    m = mainCnt;
    h = 1'b0;
    for (int k = 0; k < MAX_STEPS; k++) begin
      if (k < int'(stepCnt)) begin
        if (strb.countUp) begin
          p = p + 1'b1;
          if ((p & preMask) == '0) begin
            m = m + 1'b1;
            if (m == '0) h = 1'b1;
          end
        end else if (strb.countDown) begin
          p = p - 1'b1;
          if ((p & preMask) == preMask) begin
            m = m - 1'b1;
            if (m == '1) h = 1'b1;
          end
        end
      end
    end
    preNext  = p;
    mainNext = m;
    wrapHit  = h;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      mainCnt <= '0;
      irq     <= 1'b0;
    end else begin
      preCnt  <= strb.loadPre  ? loadVal : preNext;
      mainCnt <= strb.loadMain ? loadVal : mainNext;
      irq     <= (irq || (wrapHit && strb.irqEnable)) && !strb.ackIrq;
    end
  end

endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
  import irqtmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NARROW_W   = 3,
  parameter int VA_W       = 14,
  parameter int LINE_STEPS = 8,
  parameter int VID_STEPS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             cpuTick,
  input  logic             lineTick,
  input  logic [VA_W-1:0]  vidAddr,
  output logic             irq
);

  localparam int MAX_STEPS = (LINE_STEPS > VID_STEPS) ? LINE_STEPS : VID_STEPS;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  ctlStrobes_t       strb;
  logic [STEP_W-1:0] stepCnt;
  logic [CNT_W-1:0]  loadVal;

  irqtmr_ctrl #(
    .CNT_W(CNT_W), .VA_W(VA_W), .LINE_STEPS(LINE_STEPS),
    .VID_STEPS(VID_STEPS), .STEP_W(STEP_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuTick(cpuTick), .lineTick(lineTick), .vidAddr(vidAddr),
    .strb(strb), .stepCnt(stepCnt), .loadVal(loadVal)
  );

  irqtmr_core #(
    .CNT_W(CNT_W), .NARROW_W(NARROW_W), .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)
  ) i_core (
    .clk(clk), .rst(rst), .strb(strb), .stepCnt(stepCnt),
    .loadVal(loadVal), .irq(irq)
  );

endmodule

// File: rtl/irqtmr_check.sv
module irqtmr_check
  import irqtmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input ctlStrobes_t       strb,
  input logic [STEP_W-1:0] stepCnt,
  input logic [CNT_W-1:0]  loadVal,
  input logic [CNT_W-1:0]  preCnt,
  input logic [CNT_W-1:0]  mainCnt,
  input logic              irq
);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    strb.ackIrq |=> !irq);

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !strb.ackIrq) |=> irq);

  a_r8_pre_load: assert property (@(posedge clk) disable iff (rst)
    strb.loadPre |=> (preCnt == $past(loadVal)));

  a_r8_main_load: assert property (@(posedge clk) disable iff (rst)
    strb.loadMain |=> (mainCnt == $past(loadVal)));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (stepCnt == '0 && !strb.loadPre && !strb.loadMain) |=> ($stable(preCnt) && $stable(mainCnt)));

  a_r3_single_up: assert property (@(posedge clk) disable iff (rst)
    (stepCnt == STEP_W'(1) && strb.countUp && !strb.loadPre) |=>
      (preCnt == CNT_W'($past(preCnt) + 1'b1)));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!irq && !strb.irqEnable) |=> !irq);

endmodule

bind irqtmr_core irqtmr_check #(.CNT_W(CNT_W), .STEP_W(STEP_W)) i_check (
  .clk(clk), .rst(rst), .strb(strb), .stepCnt(stepCnt), .loadVal(loadVal),
  .preCnt(preCnt), .mainCnt(mainCnt), .irq(irq)
);

// File: tb/test_irq_tick_timer.sv
module test_irq_tick_timer;

  localparam int VA_W = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wrEn = 1'b0;
  logic [2:0]      wrAddr = '0;
  logic [7:0]      wrData = '0;
  logic            cpuTick = 1'b0;
  logic            lineTick = 1'b0;
  logic [VA_W-1:0] vidAddr = '0;
  logic            irq;

  always #5 clk = ~clk;

  irq_tick_timer i_irq_tick_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuTick(cpuTick), .lineTick(lineTick), .vidAddr(vidAddr), .irq(irq)
  );

  int    vecs = 0;
  int    errs = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mPre, mMain, mKey, mEn, mDir, mNarrow, mSrc, mIrq;
  int mLast;

  always @(posedge clk) begin
    if (rst) begin
      mPre = 0; mMain = 0; mKey = 0; mEn = 0; mDir = 0;
      mNarrow = 0; mSrc = 0; mIrq = 0; mLast = 0;
    end else begin
      int steps;
      int mask;
      int hit;
      steps = 0;
      hit = 0;
      mask = mNarrow ? 7 : 255;
      if (mDir == 1 || mDir == 2) begin
        if (mSrc == 0 && cpuTick) steps = 1;
        if (mSrc == 1 && lineTick) steps = 8;
        if (mSrc == 2 && int'(vidAddr) != mLast) steps = 2;
      end
      for (int s = 0; s < steps; s++) begin
        if (mDir == 1) begin
          mPre = (mPre + 1) % 256;
          if ((mPre & mask) == 0) begin
            mMain = (mMain + 1) % 256;
            if (mMain == 0) hit = 1;
          end
        end else begin
          mPre = (mPre + 255) % 256;
          if ((mPre & mask) == mask) begin
            mMain = (mMain + 255) % 256;
            if (mMain == 255) hit = 1;
          end
        end
      end
      if (hit != 0 && mEn != 0) mIrq = 1;
      mLast = int'(vidAddr);
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mEn = int'(wrData[0]); if (!wrData[0]) mIrq = 0; end
          3'd1: begin mDir = int'(wrData[7:6]); mNarrow = int'(wrData[2]); mSrc = int'(wrData[1:0]); end
          3'd2: begin mEn = 0; mIrq = 0; end
          3'd3: mEn = 1;
          3'd4: mPre = int'(wrData) ^ mKey;
          3'd5: mMain = int'(wrData) ^ mKey;
          3'd6: mKey = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      vecs++;
      if (irq !== mIrq[0]) begin
        errs++;
        $display("FAIL %s model compare: irq=%0b expected %0b at %0t", curReq, irq, mIrq[0], $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: irq=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cpu(input int n);
    for (int i = 0; i < n; i++) begin
      cpuTick = 1'b1;
      @(negedge clk);
      cpuTick = 1'b0;
    end
  endtask

  task automatic line(input int n);
    for (int i = 0; i < n; i++) begin
      lineTick = 1'b1;
      @(negedge clk);
      lineTick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] mode, input logic [7:0] preV, input logic [7:0] mainV);
    wr(3'd2, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd4, preV);
    wr(3'd5, mainV);
    wr(3'd1, mode);
    wr(3'd3, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: run did not finish, irq=%0b expected end of test", irq);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, stopped and disabled
    curReq = "R1";
    chk("R1 reset", irq, 1'b0);
    cpu(300);
    chk("R1 stopped after reset", irq, 1'b0);

    // R3 and R5: up, narrow mask, from pre 0 main FE -> fires on tick 16
    curReq = "R3";
    setup(8'h44, 8'h00, 8'hFE);
    cpu(15);
    chk("R5 narrow up tick 15", irq, 1'b0);
    cpu(1);
    chk("R3 up wrap tick 16", irq, 1'b1);

    // R9: level held, cleared by offset 2
    curReq = "R9";
    idle(5);
    chk("R9 level held", irq, 1'b1);
    wr(3'd2, 8'h00);
    chk("R9 offset 2 clears", irq, 1'b0);
    setup(8'h44, 8'h07, 8'hFF);
    cpu(1);
    chk("R9 refire", irq, 1'b1);
    wr(3'd0, 8'h00);
    chk("R9 offset 0 bit0 clear clears", irq, 1'b0);

    // R4: down, full mask
    curReq = "R4";
    setup(8'h80, 8'h01, 8'h00);
    cpu(1);
    chk("R4 down pre 1->0 no wrap", irq, 1'b0);
    cpu(1);
    chk("R4 down wrap to FF", irq, 1'b1);

    // R5: full mask ignores low-bit rollover
    curReq = "R5";
    setup(8'h40, 8'h07, 8'hFF);
    cpu(1);
    chk("R5 full mask no step at 8", irq, 1'b0);
    setup(8'h40, 8'hFF, 8'hFF);
    cpu(1);
    chk("R5 full mask step at 0", irq, 1'b1);

    // R8: XOR-scrambled loads
    curReq = "R8";
    wr(3'd2, 8'h00);
    wr(3'd6, 8'h5A);
    wr(3'd4, 8'h5D);
    wr(3'd5, 8'hA5);
    wr(3'd1, 8'h44);
    wr(3'd3, 8'h00);
    cpu(1);
    chk("R8 xor load", irq, 1'b1);

    // R2: stopped modes hold state
    curReq = "R2";
    setup(8'h04, 8'h07, 8'hFF);
    cpu(20);
    chk("R2 dir 00 stopped", irq, 1'b0);
    wr(3'd1, 8'hC4);
    cpu(20);
    chk("R2 dir 11 stopped", irq, 1'b0);
    wr(3'd1, 8'h44);
    cpu(1);
    chk("R2 held count resumes", irq, 1'b1);

    // R6 and R7: scanline source, eight steps per pulse
    curReq = "R6";
    setup(8'h45, 8'h00, 8'hFE);
    line(1);
    chk("R7 first line pulse", irq, 1'b0);
    line(1);
    chk("R7 second line pulse eight steps", irq, 1'b1);
    setup(8'h45, 8'h07, 8'hFF);
    cpu(5);
    chk("R6 cpu ignored in line mode", irq, 1'b0);

    // R6: video address change, two steps
    setup(8'h46, 8'h06, 8'hFF);
    idle(4);
    chk("R6 steady address no tick", irq, 1'b0);
    vidAddr = 14'h1234;
    @(negedge clk);
    chk("R6 address change two steps", irq, 1'b1);
    setup(8'h47, 8'h07, 8'hFF);
    cpu(3); line(3);
    vidAddr = 14'h0042;
    @(negedge clk);
    chk("R6 source 3 no ticks", irq, 1'b0);

    // R10: wrap while disabled
    curReq = "R10";
    setup(8'h44, 8'h07, 8'hFF);
    wr(3'd0, 8'h00);
    cpu(1);
    chk("R10 wrap while disabled", irq, 1'b0);
    wr(3'd3, 8'h00);
    chk("R10 no retroactive irq", irq, 1'b0);

    // R9: clear wins over same-cycle wrap
    curReq = "R9";
    setup(8'h44, 8'h07, 8'hFF);
    cpuTick = 1'b1; wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'h00;
    @(negedge clk);
    cpuTick = 1'b0; wrEn = 1'b0;
    chk("R9 ack beats wrap", irq, 1'b0);

    // R11: offset 7 has no effect
    curReq = "R11";
    setup(8'h44, 8'h00, 8'hFE);
    wr(3'd7, 8'hFF);
    wr(3'd7, 8'h00);
    cpu(15);
    chk("R11 size write no effect early", irq, 1'b0);
    cpu(1);
    chk("R11 size write no effect fire", irq, 1'b1);

    // R7: random mix compared to the model every clock
    curReq = "R7";
    wr(3'd2, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      wrEn     = ($urandom_range(0, 7) == 0);
      wrAddr   = 3'($urandom_range(0, 7));
      wrData   = 8'($urandom_range(0, 255));
      if (wrEn && wrAddr == 3'd1) wrData[7:6] = ($urandom_range(0, 3) == 0) ? 2'b00 : 2'($urandom_range(1, 2));
      cpuTick  = ($urandom_range(0, 1) == 1);
      lineTick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) vidAddr = 14'($urandom_range(0, 16383));
      @(negedge clk);
    end
    wrEn = 1'b0; cpuTick = 1'b0; lineTick = 1'b0;
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule